// File: doc/BRIEF.md
# Branch prediction count reporter

This block sits beside a branch-predicting trace encoder and counts how many branches in a row the predictor guessed correctly. A long run of correct guesses is not worth a branch map, so once the run reaches 31 or more, the run is closed by a single count record when one of two things happens. The first is a branch that the predictor got wrong. The second is a request from the encoder to report an address. Shorter runs are dropped here, because the branch-map path reports them.

Each record gives a count of correct predictions with 31 taken off, and a two-bit format code:
- `00`: the record has no address, and the branch that followed the run was mispredicted.
- `10`: the record carries an address and every branch in it was predicted correctly.
- `11`: the record carries an address, and that address is a branch that was mispredicted.

The address is sent as the difference from the previous address that was sent. The notify flag is folded against the most significant bit of that difference, so a decoder only notices notify when the two bits disagree. The run counter saturates at its maximum value and does not wrap.

Top module: `bp_count_reporter`

## Requirements
- R1: After reset `rec_valid` is low, the run counter is zero and the address base is zero.
- R2: Each cycle with `br_valid` and `br_hit` both high adds one to the run. `rec_count` equals the run length minus `MIN_RUN` (31). A correct branch in the same cycle as an address request is included.
- R3: A mispredicted branch (`br_valid` high, `br_hit` low) without `addr_req`, with a run of at least 31, produces a record one cycle later with `rec_fmt` = 00 and `rec_addr` = 0.
- R4: A misprediction or an address request with a run shorter than 31 produces no record, and it still clears the run.
- R5: `addr_req` without a misprediction, with a run of at least 31, produces a record with `rec_fmt` = 10 that carries the address.
- R6: `addr_req` together with a misprediction, with a run of at least 31, produces a record with `rec_fmt` = 11 that carries the address.
- R7: `rec_fmt` is never 01 while `rec_valid` is high.
- R8: `rec_addr` in an address record equals `addr_in` minus the previous address sent in a record, modulo 2^AW. The base then becomes `addr_in`.
- R9: `rec_notify` equals `notify_in` XOR bit AW-1 of `rec_addr`. For a record with no address it equals `notify_in`.
- R10: The run counter holds at 2^CW-1 and does not wrap. With CW=6 a long run reports a count of 32.
- R11: Any misprediction or address request resets the run to zero. `br_hit` has no effect while `br_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch retired this cycle |
| br_hit | input | 1 | That branch was predicted correctly |
| addr_req | input | 1 | Encoder requests an address report |
| addr_in | input | AW | Instruction address for the report |
| notify_in | input | 1 | Notify flag to be encoded |
| rec_valid | output | 1 | A record is presented this cycle |
| rec_count | output | CW | Correct predictions minus 31 |
| rec_fmt | output | 2 | Format code 00, 10 or 11 |
| rec_addr | output | AW | Differential address, or zero |
| rec_notify | output | 1 | Notify folded against address MSB |

## Verification
A run counter that is off by one shows up in the very next record as a `rec_count` that is one too high or one too low. If the counter is not cleared, the error shows up in the record after that. A base register that is wrong leaves the next differential address wrong, and because the notify bit is folded against that address, `rec_notify` can also flip. Records that appear or go missing at the threshold of 31 show on `rec_valid` one cycle after the branch that should have closed the run. A counter that wraps instead of saturating is caught by a narrow instance whose count would drop far below 32.

// File: rtl/bp_count_reporter.sv
module bp_count_reporter #(
  parameter int CW      = 32,
  parameter int AW      = 32,
  parameter int MIN_RUN = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_valid,
  input  logic          br_hit,
  input  logic          addr_req,
  input  logic [AW-1:0] addr_in,
  input  logic          notify_in,
  output logic          rec_valid,
  output logic [CW-1:0] rec_count,
  output logic [1:0]    rec_fmt,
  output logic [AW-1:0] rec_addr,
  output logic          rec_notify
);
  localparam logic [CW-1:0] RUN_MAX = '1;
  localparam logic [CW-1:0] RUN_MIN = CW'(MIN_RUN);

  logic [CW-1:0] run_q;
  logic [AW-1:0] base_q;

  wire hit  = br_valid & br_hit;
  wire miss = br_valid & ~br_hit;
  wire done = miss | addr_req;

  wire [CW-1:0] run_nx = (hit && run_q != RUN_MAX) ? run_q + 1'b1 : run_q;
  wire          emit   = done && (run_nx >= RUN_MIN);
  wire [AW-1:0] delta  = addr_in - base_q;
  wire [1:0]    fmt    = addr_req ? {1'b1, miss} : 2'b00;
  wire [AW-1:0] addr_o = addr_req ? delta : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q      <= '0;
      base_q     <= '0;
      rec_valid  <= 1'b0;
      rec_count  <= '0;
      rec_fmt    <= 2'b00;
      rec_addr   <= '0;
      rec_notify <= 1'b0;
    end else begin
      rec_valid <= emit;
      run_q     <= done ? '0 : run_nx;
      if (emit) begin
        rec_count  <= run_nx - RUN_MIN;
        rec_fmt    <= fmt;
        rec_addr   <= addr_o;
        rec_notify <= notify_in ^ addr_o[AW-1];
        if (addr_req) base_q <= addr_in;
      end
    end
  end
endmodule

// File: rtl/bp_count_reporter_chk.sv
module bp_count_reporter_chk #(
  parameter int CW      = 32,
  parameter int AW      = 32,
  parameter int MIN_RUN = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_valid,
  input logic          br_hit,
  input logic          addr_req,
  input logic          rec_valid,
  input logic [1:0]    rec_fmt,
  input logic [AW-1:0] rec_addr,
  input logic [CW-1:0] run_q
);
  localparam logic [CW-1:0] RUN_MAX = '1;
  localparam logic [CW-1:0] RUN_MIN = CW'(MIN_RUN);

  a_r7_no_fmt01: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_fmt != 2'b01);

  a_r3_no_addr_on_00: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_fmt == 2'b00) |-> rec_addr == '0);

  a_r3_long_miss_reports: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_hit && run_q >= RUN_MIN) |=> rec_valid);

  a_r4_short_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_hit && !addr_req && run_q < RUN_MIN) |=> !rec_valid);

  a_r11_cleared_after_record: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> run_q == '0);

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == RUN_MAX) |=> (run_q == RUN_MAX || run_q == '0));
endmodule

bind bp_count_reporter bp_count_reporter_chk #(.CW(CW), .AW(AW), .MIN_RUN(MIN_RUN)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_hit(br_hit),
  .addr_req(addr_req), .rec_valid(rec_valid), .rec_fmt(rec_fmt),
  .rec_addr(rec_addr), .run_q(run_q)
);

// File: tb/test_bp_count_reporter.sv
module test_bp_count_reporter;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_valid = 1'b0, br_hit = 1'b0, addr_req = 1'b0, notify_in = 1'b0;
  logic [AW-1:0] addr_in = '0;

  logic          m_v, s_v, m_n, s_n;
  logic [31:0]   m_c;
  logic [5:0]    s_c;
  logic [1:0]    m_f, s_f;
  logic [AW-1:0] m_a, s_a;

  int vectors = 0, fails = 0;

  longint unsigned mr_run = 0, sr_run = 0;
  logic [AW-1:0] mr_base = '0, sr_base = '0;

  logic          e_v[2], e_n[2];
  longint unsigned e_c[2];
  logic [1:0]    e_f[2];
  logic [AW-1:0] e_a[2];

  always #4 clk = ~clk;

  bp_count_reporter #(.CW(32), .AW(AW), .MIN_RUN(31)) i_bp_count_reporter (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_hit(br_hit),
    .addr_req(addr_req), .addr_in(addr_in), .notify_in(notify_in),
    .rec_valid(m_v), .rec_count(m_c), .rec_fmt(m_f), .rec_addr(m_a), .rec_notify(m_n));

  bp_count_reporter #(.CW(6), .AW(AW), .MIN_RUN(31)) i_sat (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_hit(br_hit),
    .addr_req(addr_req), .addr_in(addr_in), .notify_in(notify_in),
    .rec_valid(s_v), .rec_count(s_c), .rec_fmt(s_f), .rec_addr(s_a), .rec_notify(s_n));

  task automatic model(input longint unsigned maxv, inout longint unsigned run,
                       inout logic [AW-1:0] base, output logic ev, output longint unsigned ec,
                       output logic [1:0] ef, output logic [AW-1:0] ea, output logic en);
    logic hit, miss, done;
    longint unsigned tot;
    hit  = br_valid & br_hit;
    miss = br_valid & ~br_hit;
    done = miss | addr_req;
    tot  = (hit && run < maxv) ? run + 1 : run;   // R2, R10
    ev   = done && tot >= 31;                     // R3, R4
    ec   = tot - 31;
    ef   = addr_req ? (miss ? 2'b11 : 2'b10) : 2'b00; // R5, R6
    ea   = addr_req ? addr_in - base : '0;        // R8
    en   = notify_in ^ ea[AW-1];                  // R9
    if (ev && addr_req) base = addr_in;
    run  = done ? 0 : tot;                        // R11
  endtask

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic h, input logic a,
                      input logic [AW-1:0] ad, input logic n);
    @(negedge clk);
    br_valid = v; br_hit = h; addr_req = a; addr_in = ad; notify_in = n;
    model(64'hFFFF_FFFF, mr_run, mr_base, e_v[0], e_c[0], e_f[0], e_a[0], e_n[0]);
    model(64'd63, sr_run, sr_base, e_v[1], e_c[1], e_f[1], e_a[1], e_n[1]);
    @(posedge clk); #1;
    chk("R4 valid", m_v, e_v[0]);
    if (m_v && e_v[0]) begin
      chk("R2 count", m_c, e_c[0]);
      chk(e_f[0] == 2'b00 ? "R3 fmt" : (e_f[0] == 2'b10 ? "R5 fmt" : "R6 fmt"), m_f, e_f[0]);
      chk("R8 addr", m_a, e_a[0]);
      chk("R9 notify", m_n, e_n[0]);
    end
    chk("R10 sat valid", s_v, e_v[1]);
    if (s_v && e_v[1]) chk("R10 sat count", s_c, e_c[1]);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", m_v, 0);
    chk("R1 reset valid sat", s_v, 0);
    @(negedge clk); rst_n = 1'b1;

    // R4: 30 hits then a miss gives nothing
    for (int i = 0; i < 30; i++) step(1, 1, 0, '0, 0);
    step(1, 0, 0, '0, 0);
    // R3: exactly 31 hits then a miss gives count 0
    for (int i = 0; i < 31; i++) step(1, 1, 0, '0, 0);
    step(1, 0, 0, '0, 1);
    // R11: br_hit alone is ignored; R5 with hit in same cycle
    for (int i = 0; i < 30; i++) begin step(1, 1, 0, '0, 0); step(0, 1, 0, '0, 0); end
    step(1, 1, 1, 32'h8000_1000, 1);
    // R6 address with miss; R8 differential from previous
    for (int i = 0; i < 40; i++) step(1, 1, 0, '0, 0);
    step(1, 0, 1, 32'h0000_0800, 0);
    // R10: long run on narrow instance saturates
    for (int i = 0; i < 100; i++) step(1, 1, 0, '0, 0);
    step(0, 0, 1, 32'h1234_5678, 1);

    for (int i = 0; i < 20000; i++) begin
      logic v, h, a, n;
      v = ($urandom % 4) != 0;
      h = ($urandom % 64) != 0;
      a = ($urandom % 48) == 0;
      n = $urandom % 2;
      step(v, h, a, $urandom, n);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule